// File: doc/BRIEF.md
# Single-Cycle Datapath Control Decoder

This block is the control layer of a processor that finishes one instruction per clock. It sits between the fetched instruction fields and the datapath. From the opcode, the two register-specifier fields and the branch flag, it picks the register-file port addresses, the two ALU operands, the ALU function, the data-memory controls and the next program counter. It builds its outputs from the values the datapath already holds.

The decoder is purely combinational. It holds no state, and every output follows its inputs within the same cycle. The register file has two read ports (A, B) and two write ports (E for ALU results, M for memory results). Register ID 0xF means "no register" on any of the four ports. Register 4 is the stack pointer. Push, pop, call and return use it as their implicit operand and destination. The decoder feeds the constant step of plus or minus 4 into the ALU for stack adjustment. It chooses the next PC from three sources: the constant word, the memory read value and the incremented PC.

Opcode encoding: 0 halt, 1 nop, 2 register move, 3 immediate move, 4 register-to-memory move, 5 memory-to-register move, 6 ALU op, 7 jump, 8 call, 9 return, 0xA push, 0xB pop. Codes 0xC to 0xF are unrecognised.

Top module: `seq_ctrl_decoder`

## Requirements
- R1: `src_a` is `ra` for register move, register-to-memory move, ALU op and push. It is 4 for pop and return, and 0xF for every other code.
- R2: `src_b` is `rb` for ALU op and both memory moves. It is 4 for push, pop, call and return, and 0xF for every other code.
- R3: `dst_e` is `rb` for register move, immediate move and ALU op. It is 4 for push, pop, call and return, and 0xF for every other code.
- R4: `dst_m` is `ra` for memory-to-register move and pop, and 0xF for every other code. A pop therefore writes two registers: M gets `ra` and E gets 4.
- R5: `alu_a` is `val_a` for register move and ALU op. It is `val_c` for immediate move and both memory moves. It is -4 (0xFFFFFFFC) for call and push, +4 for return and pop, and 0 for every other code.
- R6: `alu_b` is 0 for register move and immediate move, and `val_b` for every other code. `alu_fun` equals `ifun` for ALU op and 0 (add) for every other code.
- R7: `mem_read` is 1 only for memory-to-register move, pop and return. `mem_write` is 1 only for register-to-memory move, push and call. The two are never 1 together.
- R8: `mem_addr` is `val_e` for both memory moves, push and call. It is `val_a` for pop and return, and 0 for every other code. `mem_data` is `val_p` for call and `val_a` for every other code.
- R9: `new_pc` is `val_c` for call and for a jump with `cnd`=1. It is `val_m` for return, and `val_p` for every other case, including a jump with `cnd`=0.
- R10: Codes 0xC to 0xF, halt and nop have no effect. All four register IDs are 0xF, both memory strobes are 0, and `new_pc` is `val_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| icode | input | 4 | Opcode of the current instruction |
| ifun | input | 4 | Function field (ALU operation or jump condition) |
| ra | input | 4 | First register specifier |
| rb | input | 4 | Second register specifier |
| val_a | input | 32 | Value read on register port A |
| val_b | input | 32 | Value read on register port B |
| val_c | input | 32 | Constant word of the instruction |
| val_e | input | 32 | ALU result |
| val_m | input | 32 | Data-memory read value |
| val_p | input | 32 | Incremented PC |
| cnd | input | 1 | Branch flag from the condition evaluator |
| src_a | output | 4 | Read port A address |
| src_b | output | 4 | Read port B address |
| dst_e | output | 4 | Write port E address |
| dst_m | output | 4 | Write port M address |
| alu_a | output | 32 | ALU operand A |
| alu_b | output | 32 | ALU operand B |
| alu_fun | output | 4 | ALU function |
| mem_read | output | 1 | Data-memory read strobe |
| mem_write | output | 1 | Data-memory write strobe |
| mem_addr | output | 32 | Data-memory address |
| mem_data | output | 32 | Data-memory write value |
| new_pc | output | 32 | Next program counter |

## Verification
The assertions assume that the inputs have settled to known values before they are checked. They also assume that no register specifier relies on a stack-pointer value other than 4. The checker evaluates them after every input change. The stimulus sets each input once per scenario and samples one time unit later. It uses a distinct value on each datapath bus, so any wrong selection shows up as a mismatch. It also covers every unrecognised code, so the default paths are exercised and nothing undefined reaches the datapath.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
  localparam int REG_ID_W = 4;
  localparam int OP_W     = 4;
  localparam logic [REG_ID_W-1:0] REG_NONE = '1;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMV  = 4'h2,
    OP_IRMV  = 4'h3,
    OP_RMMV  = 4'h4,
    OP_MRMV  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } op_e;

  localparam logic [OP_W-1:0] ALU_ADD = 4'h0;
endpackage

// File: rtl/seq_regport_dec.sv
module seq_regport_dec
  import seq_ctrl_pkg::*;
#(
  parameter logic [REG_ID_W-1:0] SP_ID = 4'd4
) (
  input  logic [OP_W-1:0]     icode,
  input  logic [REG_ID_W-1:0] ra,
  input  logic [REG_ID_W-1:0] rb,
  output logic [REG_ID_W-1:0] src_a,
  output logic [REG_ID_W-1:0] src_b,
  output logic [REG_ID_W-1:0] dst_e,
  output logic [REG_ID_W-1:0] dst_m
);
  op_e op;
  assign op = op_e'(icode);

  always_comb begin
    src_a = REG_NONE;
    src_b = REG_NONE;
    dst_e = REG_NONE;
    dst_m = REG_NONE;
    case (op)
      OP_RRMV: begin src_a = ra; dst_e = rb; end
      OP_IRMV: begin dst_e = rb; end
      OP_RMMV: begin src_a = ra; src_b = rb; end
      OP_MRMV: begin src_b = rb; dst_m = ra; end
      OP_ALU:  begin src_a = ra; src_b = rb; dst_e = rb; end
      OP_PUSH: begin src_a = ra; src_b = SP_ID; dst_e = SP_ID; end
      OP_POP:  begin src_a = SP_ID; src_b = SP_ID; dst_e = SP_ID; dst_m = ra; end
      OP_CALL: begin src_b = SP_ID; dst_e = SP_ID; end
      OP_RET:  begin src_a = SP_ID; src_b = SP_ID; dst_e = SP_ID; end
      default: ;
    endcase
  end
endmodule

// File: rtl/seq_alu_sel.sv
module seq_alu_sel
  import seq_ctrl_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int STACK_STEP = 4
) (
  input  logic [OP_W-1:0]   icode,
  input  logic [OP_W-1:0]   ifun,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  output logic [WORD_W-1:0] alu_a,
  output logic [WORD_W-1:0] alu_b,
  output logic [OP_W-1:0]   alu_fun
);
  localparam logic [WORD_W-1:0] STEP_UP   = WORD_W'(STACK_STEP);
  localparam logic [WORD_W-1:0] STEP_DOWN = WORD_W'(-STACK_STEP);

  op_e op;
  assign op = op_e'(icode);

  always_comb begin
    alu_a = '0;
    case (op)
      OP_RRMV, OP_ALU:          alu_a = val_a;
      OP_IRMV, OP_RMMV, OP_MRMV: alu_a = val_c;
      OP_CALL, OP_PUSH:         alu_a = STEP_DOWN;
      OP_RET, OP_POP:           alu_a = STEP_UP;
      default: ;
    endcase
  end

  always_comb begin
    alu_b = val_b;
    if (op == OP_RRMV || op == OP_IRMV) alu_b = '0;
  end

  always_comb alu_fun = (op == OP_ALU) ? ifun : ALU_ADD;
endmodule

// File: rtl/seq_mem_ctrl.sv
module seq_mem_ctrl
  import seq_ctrl_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [OP_W-1:0]   icode,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_e,
  input  logic [WORD_W-1:0] val_p,
  output logic              mem_read,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data
);
  op_e op;
  assign op = op_e'(icode);

  always_comb begin
    mem_read  = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    case (op)
      OP_RMMV, OP_PUSH, OP_CALL: begin mem_write = 1'b1; mem_addr = val_e; end
      OP_MRMV:                   begin mem_read  = 1'b1; mem_addr = val_e; end
      OP_POP, OP_RET:            begin mem_read  = 1'b1; mem_addr = val_a; end
      default: ;
    endcase
  end

  always_comb mem_data = (op == OP_CALL) ? val_p : val_a;
endmodule

// File: rtl/seq_pc_sel.sv
module seq_pc_sel
  import seq_ctrl_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [OP_W-1:0]   icode,
  input  logic              cnd,
  input  logic [WORD_W-1:0] val_c,
  input  logic [WORD_W-1:0] val_m,
  input  logic [WORD_W-1:0] val_p,
  output logic [WORD_W-1:0] new_pc
);
  op_e op;
  assign op = op_e'(icode);

  always_comb begin
    if (op == OP_CALL || (op == OP_JUMP && cnd)) new_pc = val_c;
    else if (op == OP_RET)                       new_pc = val_m;
    else                                         new_pc = val_p;
  end
endmodule

// File: rtl/seq_ctrl_decoder.sv
module seq_ctrl_decoder
  import seq_ctrl_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int STACK_STEP = 4,
  parameter logic [REG_ID_W-1:0] SP_ID = 4'd4
) (
  input  logic [OP_W-1:0]     icode,
  input  logic [OP_W-1:0]     ifun,
  input  logic [REG_ID_W-1:0] ra,
  input  logic [REG_ID_W-1:0] rb,
  input  logic [WORD_W-1:0]   val_a,
  input  logic [WORD_W-1:0]   val_b,
  input  logic [WORD_W-1:0]   val_c,
  input  logic [WORD_W-1:0]   val_e,
  input  logic [WORD_W-1:0]   val_m,
  input  logic [WORD_W-1:0]   val_p,
  input  logic                cnd,
  output logic [REG_ID_W-1:0] src_a,
  output logic [REG_ID_W-1:0] src_b,
  output logic [REG_ID_W-1:0] dst_e,
  output logic [REG_ID_W-1:0] dst_m,
  output logic [WORD_W-1:0]   alu_a,
  output logic [WORD_W-1:0]   alu_b,
  output logic [OP_W-1:0]     alu_fun,
  output logic                mem_read,
  output logic                mem_write,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_data,
  output logic [WORD_W-1:0]   new_pc
);
  seq_regport_dec #(.SP_ID(SP_ID)) u_regs (
    .icode(icode), .ra(ra), .rb(rb),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m)
  );

  seq_alu_sel #(.WORD_W(WORD_W), .STACK_STEP(STACK_STEP)) u_alu (
    .icode(icode), .ifun(ifun), .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .alu_a(alu_a), .alu_b(alu_b), .alu_fun(alu_fun)
  );

  seq_mem_ctrl #(.WORD_W(WORD_W)) u_mem (
    .icode(icode), .val_a(val_a), .val_e(val_e), .val_p(val_p),
    .mem_read(mem_read), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  seq_pc_sel #(.WORD_W(WORD_W)) u_pc (
    .icode(icode), .cnd(cnd), .val_c(val_c), .val_m(val_m), .val_p(val_p),
    .new_pc(new_pc)
  );
endmodule

// File: rtl/seq_ctrl_decoder_chk.sv
module seq_ctrl_decoder_chk
  import seq_ctrl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter logic [REG_ID_W-1:0] SP_ID = 4'd4
) (
  input logic [OP_W-1:0]     icode,
  input logic [REG_ID_W-1:0] ra,
  input logic [WORD_W-1:0]   val_a,
  input logic [WORD_W-1:0]   val_c,
  input logic [WORD_W-1:0]   val_e,
  input logic [WORD_W-1:0]   val_m,
  input logic [WORD_W-1:0]   val_p,
  input logic [REG_ID_W-1:0] src_a,
  input logic [REG_ID_W-1:0] dst_e,
  input logic [REG_ID_W-1:0] dst_m,
  input logic                mem_read,
  input logic                mem_write,
  input logic [WORD_W-1:0]   mem_addr,
  input logic [WORD_W-1:0]   mem_data,
  input logic [WORD_W-1:0]   new_pc
);
  always_comb begin
    if (!$isunknown({icode, mem_read, mem_write})) begin
      // R7
      rw_exclusive_chk: assert (!(mem_read && mem_write));
      // R8
      rd_addr_src_chk: assert (!mem_read || mem_addr == val_e || mem_addr == val_a);
      // R9
      pc_source_chk: assert (new_pc == val_c || new_pc == val_m || new_pc == val_p);
      // R4
      pop_two_ports_chk: assert (icode != 4'hB || (dst_e == SP_ID && dst_m == ra));
      // R10
      idle_no_mem_chk: assert (!(icode >= 4'hC || icode <= 4'h1) ||
                               (!mem_read && !mem_write && dst_e == REG_NONE &&
                                dst_m == REG_NONE && new_pc == val_p));
      // R8
      call_push_ret_chk: assert (icode != 4'h8 || (mem_write && mem_data == val_p));
      // R1
      ret_reads_sp_chk: assert (icode != 4'h9 || (src_a == SP_ID && mem_read));
    end
  end
endmodule

bind seq_ctrl_decoder seq_ctrl_decoder_chk #(.WORD_W(WORD_W), .SP_ID(SP_ID)) u_chk (
  .icode(icode), .ra(ra), .val_a(val_a), .val_c(val_c), .val_e(val_e),
  .val_m(val_m), .val_p(val_p), .src_a(src_a), .dst_e(dst_e), .dst_m(dst_m),
  .mem_read(mem_read), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_data(mem_data), .new_pc(new_pc)
);

// File: tb/seq_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module seq_ctrl_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] val_a, val_b, val_c, val_e, val_m, val_p;
  logic        cnd;
  logic [3:0]  src_a, src_b, dst_e, dst_m, alu_fun;
  logic [31:0] alu_a, alu_b, mem_addr, mem_data, new_pc;
  logic        mem_read, mem_write;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] VA = 32'hA1A1_0001, VB = 32'hB2B2_0002, VC = 32'hC3C3_0003,
                          VE = 32'hE4E4_0004, VM = 32'hD5D5_0005, VP = 32'hF6F6_0006;
  localparam logic [3:0] RA = 4'd2, RB = 4'd7, SP = 4'd4, NONE = 4'hF;

  seq_ctrl_decoder u_dut (
    .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .val_a(val_a), .val_b(val_b), .val_c(val_c), .val_e(val_e),
    .val_m(val_m), .val_p(val_p), .cnd(cnd),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m),
    .alu_a(alu_a), .alu_b(alu_b), .alu_fun(alu_fun),
    .mem_read(mem_read), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_data(mem_data), .new_pc(new_pc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [3:0] fn, logic c);
    @(negedge clk);
    icode = op; ifun = fn; cnd = c;
    ra = RA; rb = RB;
    val_a = VA; val_b = VB; val_c = VC; val_e = VE; val_m = VM; val_p = VP;
    #1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    icode = 0; ifun = 0; ra = 0; rb = 0; cnd = 0;
    val_a = 0; val_b = 0; val_c = 0; val_e = 0; val_m = 0; val_p = 0;
    #1;
    check("R10 reset src_a", {28'd0, src_a}, {28'd0, NONE});
    check("R10 reset dst_e", {28'd0, dst_e}, {28'd0, NONE});
    check("R10 reset strobes", {30'd0, mem_read, mem_write}, 32'd0);
    check("R10 reset new_pc", new_pc, 32'd0);
  endtask

  task automatic t_rrmv();
    apply(4'h2, 4'h5, 1'b0);
    check("R1 rrmv src_a", {28'd0, src_a}, {28'd0, RA});
    check("R2 rrmv src_b", {28'd0, src_b}, {28'd0, NONE});
    check("R3 rrmv dst_e", {28'd0, dst_e}, {28'd0, RB});
    check("R5 rrmv alu_a", alu_a, VA);
    check("R6 rrmv alu_b", alu_b, 32'd0);
    check("R6 rrmv alu_fun", {28'd0, alu_fun}, 32'd0);
  endtask

  task automatic t_irmv();
    apply(4'h3, 4'h0, 1'b0);
    check("R1 irmv src_a", {28'd0, src_a}, {28'd0, NONE});
    check("R3 irmv dst_e", {28'd0, dst_e}, {28'd0, RB});
    check("R5 irmv alu_a", alu_a, VC);
    check("R6 irmv alu_b", alu_b, 32'd0);
  endtask

  task automatic t_rmmv();
    apply(4'h4, 4'h0, 1'b0);
    check("R1 rmmv src_a", {28'd0, src_a}, {28'd0, RA});
    check("R2 rmmv src_b", {28'd0, src_b}, {28'd0, RB});
    check("R3 rmmv dst_e", {28'd0, dst_e}, {28'd0, NONE});
    check("R5 rmmv alu_a", alu_a, VC);
    check("R7 rmmv strobes", {30'd0, mem_read, mem_write}, 32'd1);
    check("R8 rmmv addr", mem_addr, VE);
    check("R8 rmmv data", mem_data, VA);
  endtask

  task automatic t_mrmv();
    apply(4'h5, 4'h0, 1'b0);
    check("R2 mrmv src_b", {28'd0, src_b}, {28'd0, RB});
    check("R4 mrmv dst_m", {28'd0, dst_m}, {28'd0, RA});
    check("R7 mrmv strobes", {30'd0, mem_read, mem_write}, 32'd2);
    check("R8 mrmv addr", mem_addr, VE);
    check("R9 mrmv new_pc", new_pc, VP);
  endtask

  task automatic t_alu();
    apply(4'h6, 4'h3, 1'b1);
    check("R1 alu src_a", {28'd0, src_a}, {28'd0, RA});
    check("R2 alu src_b", {28'd0, src_b}, {28'd0, RB});
    check("R3 alu dst_e", {28'd0, dst_e}, {28'd0, RB});
    check("R4 alu dst_m", {28'd0, dst_m}, {28'd0, NONE});
    check("R5 alu alu_a", alu_a, VA);
    check("R6 alu alu_b", alu_b, VB);
    check("R6 alu fun", {28'd0, alu_fun}, 32'd3);
  endtask

  task automatic t_jump();
    apply(4'h7, 4'h1, 1'b1);
    check("R9 jump taken", new_pc, VC);
    check("R7 jump strobes", {30'd0, mem_read, mem_write}, 32'd0);
    apply(4'h7, 4'h1, 1'b0);
    check("R9 jump not taken", new_pc, VP);
  endtask

  task automatic t_call();
    apply(4'h8, 4'h0, 1'b0);
    check("R2 call src_b", {28'd0, src_b}, {28'd0, SP});
    check("R3 call dst_e", {28'd0, dst_e}, {28'd0, SP});
    check("R5 call alu_a", alu_a, 32'hFFFF_FFFC);
    check("R6 call alu_b", alu_b, VB);
    check("R7 call strobes", {30'd0, mem_read, mem_write}, 32'd1);
    check("R8 call addr", mem_addr, VE);
    check("R8 call data", mem_data, VP);
    check("R9 call new_pc", new_pc, VC);
  endtask

  task automatic t_ret();
    apply(4'h9, 4'h0, 1'b1);
    check("R1 ret src_a", {28'd0, src_a}, {28'd0, SP});
    check("R3 ret dst_e", {28'd0, dst_e}, {28'd0, SP});
    check("R5 ret alu_a", alu_a, 32'd4);
    check("R7 ret strobes", {30'd0, mem_read, mem_write}, 32'd2);
    check("R8 ret addr", mem_addr, VA);
    check("R9 ret new_pc", new_pc, VM);
  endtask

  task automatic t_push();
    apply(4'hA, 4'h0, 1'b0);
    check("R1 push src_a", {28'd0, src_a}, {28'd0, RA});
    check("R2 push src_b", {28'd0, src_b}, {28'd0, SP});
    check("R5 push alu_a", alu_a, 32'hFFFF_FFFC);
    check("R7 push strobes", {30'd0, mem_read, mem_write}, 32'd1);
    check("R8 push data", mem_data, VA);
  endtask

  task automatic t_pop();
    apply(4'hB, 4'h0, 1'b0);
    check("R1 pop src_a", {28'd0, src_a}, {28'd0, SP});
    check("R3 pop dst_e", {28'd0, dst_e}, {28'd0, SP});
    check("R4 pop dst_m", {28'd0, dst_m}, {28'd0, RA});
    check("R5 pop alu_a", alu_a, 32'd4);
    check("R8 pop addr", mem_addr, VA);
  endtask

  task automatic t_idle_codes();
    for (int k = 0; k < 16; k++) begin
      if (k >= 2 && k <= 11) continue;
      apply(4'(k), 4'h6, 1'b1);
      check($sformatf("R10 code %0h src/dst", k), {16'd0, src_a, src_b, dst_e, dst_m}, 32'h0000_FFFF);
      check($sformatf("R10 code %0h strobes", k), {30'd0, mem_read, mem_write}, 32'd0);
      check($sformatf("R10 code %0h new_pc", k), new_pc, VP);
      check($sformatf("R10 code %0h alu_a", k), alu_a, 32'd0);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_rrmv();
    t_irmv();
    t_rmmv();
    t_mrmv();
    t_alu();
    t_jump();
    t_call();
    t_ret();
    t_push();
    t_pop();
    t_idle_codes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule